// File: doc/BRIEF.md
# Dual-Plane NAND Page Program Sequencer

This block is a host-side controller that writes two pages of an asynchronous 8-bit NAND flash in a single program operation, one page in each plane. A start request supplies two block addresses (one for each plane), a shared page index, a starting column and a byte count. The block first checks the request. It then loads the plane-0 page and closes that load with a dummy confirm. It waits out the short busy period, loads the plane-1 page, and issues one final confirm that programs both planes together. After the program busy time it reads the status byte and reports the outcome.

Write data arrives as one ready/valid byte stream. The first `nbytes` bytes go to plane 0 and the next `nbytes` bytes go to plane 1. Flash timing is expressed in clock counts. The write strobe low and high phases, the minimum wait before the ready line is trusted, and the limit on any busy wait are all parameters.

Top module: `nand_mp_prog`

## Requirements
- R1: A request is rejected if any of these holds: the plane-0 block's bit 0 is not 0, the plane-1 block's bit 0 is not 1, or the two blocks differ in any bit above bit 0. A rejected request ends with `done` high, `pass` low and `fault` = 1. It issues no bus cycle, keeps `nand_chip_n` high and takes no byte from the stream.
- R2: A request is also rejected with `fault` = 1 when `nbytes` is 0 or when `col + nbytes` exceeds PAGE_BYTES (2112 by default).
- R3: The first load is command 0x80, then five address bytes, then `nbytes` data bytes. The address bytes are column bits 7:0, column bits 15:8, then row bits 7:0, 15:8 and 23:16. The row is the block number placed above the PAGE_W page bits.
- R4: A command cycle has `nand_cmd_latch`=1 and `nand_addr_latch`=0. An address cycle has the reverse. A data cycle has both low. Each byte is latched on the rising edge of `nand_wr_n`, and the two latch lines are never high together.
- R5: After the plane-0 data comes command 0x11. The block issues no write strobe while `nand_ready` is low. Once ready returns high it sends 0x81, five address bytes built from the plane-1 block, and the plane-1 data.
- R6: After the plane-1 data comes command 0x10. Once ready returns high the block sends command 0x70 and then one read cycle, with `nand_rd_n` low for T_LO clocks.
- R7: Status bit 0 equal to 0 gives `pass`=1 and `fault`=0. Status bit 0 equal to 1 gives `pass`=0 and `fault`=3.
- R8: If `nand_ready` stays low for TIMEOUT clocks in either busy wait, the operation ends with `pass`=0 and `fault`=2, and no status read is made.
- R9: A stream byte is taken only in a cycle where `din_valid` and `din_ready` are both high. Bytes are used in arrival order, and gaps in `din_valid` only delay the load.
- R10: Every write strobe holds `nand_wr_n` low for exactly T_LO clocks and then high for T_HI clocks.
- R11: `nand_chip_n` is low from the first command until the status read ends, and high while idle. `nand_wr_n` never falls while `nand_chip_n` is high. `done` is a one-clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, sampled while idle |
| blk_p0 | input | BLK_W | Block for the plane-0 page |
| blk_p1 | input | BLK_W | Block for the plane-1 page |
| page | input | PAGE_W | Page index inside both blocks |
| col | input | COL_W | First column written in both pages |
| nbytes | input | NB_W | Bytes loaded into each plane |
| din_valid | input | 1 | Stream byte available |
| din_data | input | 8 | Stream byte |
| din_ready | output | 1 | Stream byte taken this cycle |
| done | output | 1 | One-clock end-of-operation pulse |
| pass | output | 1 | Both pages programmed, valid with done |
| fault | output | 2 | 0 none, 1 bad request, 2 busy timeout, 3 program fail |
| nand_chip_n | output | 1 | Chip enable, active low |
| nand_cmd_latch | output | 1 | Command latch enable |
| nand_addr_latch | output | 1 | Address latch enable |
| nand_wr_n | output | 1 | Write strobe, active low |
| nand_rd_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Byte driven to the flash |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 8 | Byte returned by the flash |
| nand_ready | input | 1 | Flash ready (high) or busy (low) |

## Verification
The assertions assume that `nand_ready` goes low only in response to a confirm command. They also assume that `start` arrives only while the block is idle. The bench flash model meets both assumptions: it drops ready after it latches 0x11 or 0x10, and it raises ready again after a fixed count or, in the timeout case, holds it low until the operation has ended. Stimulus waits for each `done` pulse before the next request, so no request overlaps a running operation. Stream gaps are produced by withholding `din_valid` and never by changing data while a byte is being offered.

// File: rtl/nmp_pkg.sv
package nmp_pkg;

    typedef enum logic [1:0] {
        CYC_CMD  = 2'd0,
        CYC_ADDR = 2'd1,
        CYC_DATA = 2'd2,
        CYC_READ = 2'd3
    } cyc_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_ADDR    = 2'd1,
        FLT_TIMEOUT = 2'd2,
        FLT_PROG    = 2'd3
    } fault_e;

    typedef struct packed {
        cyc_kind_e  kind;
        logic [7:0] val;
    } bus_cyc_t;

    typedef enum logic [3:0] {
        S_IDLE, S_OP0, S_ADR0, S_DAT0, S_OPD, S_WD,
        S_OP1, S_ADR1, S_DAT1, S_OPP, S_WP, S_OPS, S_RDS, S_FIN
    } seq_e;

    localparam logic [7:0] OP_LOAD0 = 8'h80;
    localparam logic [7:0] OP_LOAD1 = 8'h81;
    localparam logic [7:0] OP_DUMMY = 8'h11;
    localparam logic [7:0] OP_PROG  = 8'h10;
    localparam logic [7:0] OP_STAT  = 8'h70;
    localparam logic [7:0] STAT_FAIL_MASK = 8'h01;
    localparam logic [2:0] ADDR_LAST = 3'd4;

    function automatic logic [7:0] addr_byte(input logic [15:0] c,
                                             input logic [23:0] r,
                                             input logic [2:0]  idx);
        case (idx)
            3'd0:    return c[7:0];
            3'd1:    return c[15:8];
            3'd2:    return r[7:0];
            3'd3:    return r[15:8];
            default: return r[23:16];
        endcase
    endfunction

endpackage

// File: rtl/nmp_cycle_drv.sv
module nmp_cycle_drv
    import nmp_pkg::*;
#(
    parameter int T_LO = 2,
    parameter int T_HI = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  bus_cyc_t   cyc,
    output logic       idle,
    output logic       fin,
    output logic [7:0] rd_byte,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] io_out,
    output logic       io_oe,
    input  logic [7:0] io_in
);
    localparam int TMAXP = (T_LO > T_HI) ? T_LO : T_HI;
    localparam int TW = $clog2(TMAXP + 1);
    localparam logic [TW-1:0] LO_LAST = TW'(T_LO - 1);
    localparam logic [TW-1:0] HI_LAST = TW'(T_HI - 1);

    typedef enum logic [1:0] {PH_IDLE, PH_LO, PH_HI} ph_e;

    ph_e           ph;
    logic [TW-1:0] cnt;
    bus_cyc_t      cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            cnt     <= '0;
            cur     <= '0;
            rd_byte <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (go) begin
                    cur <= cyc;
                    ph  <= PH_LO;
                    cnt <= '0;
                end
                PH_LO: if (cnt == LO_LAST) begin
                    ph  <= PH_HI;
                    cnt <= '0;
                    if (cur.kind == CYC_READ) rd_byte <= io_in;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: if (cnt == HI_LAST) begin
                    ph  <= PH_IDLE;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    assign idle   = (ph == PH_IDLE);
    assign fin    = (ph == PH_HI) && (cnt == HI_LAST);
    assign cle    = (ph != PH_IDLE) && (cur.kind == CYC_CMD);
    assign ale    = (ph != PH_IDLE) && (cur.kind == CYC_ADDR);
    assign we_n   = !((ph == PH_LO) && (cur.kind != CYC_READ));
    assign re_n   = !((ph == PH_LO) && (cur.kind == CYC_READ));
    assign io_out = cur.val;
    assign io_oe  = (ph != PH_IDLE) && (cur.kind != CYC_READ);

    logic [TW:0] lo_run;
    always_ff @(posedge clk) begin
        if (rst || we_n) lo_run <= '0;
        else             lo_run <= lo_run + 1'b1;
    end

    // R10
    we_low_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> lo_run == (TW+1)'(T_LO));

endmodule

// File: rtl/nmp_busy_wait.sv
module nmp_busy_wait #(
    parameter int T_WB    = 2,
    parameter int TIMEOUT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic rb_n,
    output logic ready,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] TMAX = CW'(TIMEOUT);
    localparam logic [CW-1:0] WB   = CW'(T_WB);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)        cnt <= '0;
        else if (cnt != TMAX)  cnt <= cnt + 1'b1;
    end

    assign ready   = en && rb_n && (cnt >= WB);
    assign expired = en && !ready && (cnt == TMAX);

    // R8
    wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
        expired |=> !en);

endmodule

// File: rtl/nand_mp_prog.sv
module nand_mp_prog
    import nmp_pkg::*;
#(
    parameter int BLK_W      = 11,
    parameter int PAGE_W     = 6,
    parameter int COL_W      = 12,
    parameter int PAGE_BYTES = 2112,
    parameter int T_LO       = 2,
    parameter int T_HI       = 2,
    parameter int T_WB       = 2,
    parameter int TIMEOUT    = 1000,
    localparam int NB_W      = $clog2(PAGE_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BLK_W-1:0]  blk_p0,
    input  logic [BLK_W-1:0]  blk_p1,
    input  logic [PAGE_W-1:0] page,
    input  logic [COL_W-1:0]  col,
    input  logic [NB_W-1:0]   nbytes,
    input  logic              din_valid,
    input  logic [7:0]        din_data,
    output logic              din_ready,
    output logic              done,
    output logic              pass,
    output logic [1:0]        fault,
    output logic              nand_chip_n,
    output logic              nand_cmd_latch,
    output logic              nand_addr_latch,
    output logic              nand_wr_n,
    output logic              nand_rd_n,
    output logic [7:0]        nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [7:0]        nand_dq_in,
    input  logic              nand_ready
);
    seq_e              state;
    logic [BLK_W-1:0]  blk0_r, blk1_r;
    logic [PAGE_W-1:0] page_r;
    logic [COL_W-1:0]  col_r;
    logic [NB_W-1:0]   nb_r, cnt;
    logic              pend, pass_r;
    fault_e            fault_r;

    logic       drv_idle, drv_fin, go, want;
    logic [7:0] rd_byte;
    bus_cyc_t   cyc;
    logic       tmr_en, tmr_ready, tmr_expired;
    logic       req_ok, stat_fail;
    logic [15:0] col16;
    logic [23:0] row0, row1;

    assign col16 = 16'(col_r);
    assign row0  = 24'({blk0_r, page_r});
    assign row1  = 24'({blk1_r, page_r});

    always_comb begin
        req_ok = !blk_p0[0] && blk_p1[0]
              && (blk_p0[BLK_W-1:1] == blk_p1[BLK_W-1:1])
              && (nbytes != '0)
              && ((int'(col) + int'(nbytes)) <= PAGE_BYTES);
    end

    always_comb begin
        cyc  = '{kind: CYC_CMD, val: 8'h00};
        want = 1'b0;
        case (state)
            S_OP0: begin cyc.val = OP_LOAD0; want = 1'b1; end
            S_OPD: begin cyc.val = OP_DUMMY; want = 1'b1; end
            S_OP1: begin cyc.val = OP_LOAD1; want = 1'b1; end
            S_OPP: begin cyc.val = OP_PROG;  want = 1'b1; end
            S_OPS: begin cyc.val = OP_STAT;  want = 1'b1; end
            S_ADR0, S_ADR1: begin
                cyc.kind = CYC_ADDR;
                cyc.val  = addr_byte(col16, (state == S_ADR0) ? row0 : row1, cnt[2:0]);
                want     = 1'b1;
            end
            S_DAT0, S_DAT1: begin
                cyc.kind = CYC_DATA;
                cyc.val  = din_data;
                want     = din_valid;
            end
            S_RDS: begin cyc.kind = CYC_READ; want = 1'b1; end
            default: ;
        endcase
    end

    assign go        = want && !pend && drv_idle;
    assign din_ready = go && ((state == S_DAT0) || (state == S_DAT1));
    assign tmr_en    = (state == S_WD) || (state == S_WP);
    assign stat_fail = |(rd_byte & STAT_FAIL_MASK);

    always_ff @(posedge clk) begin
        if (rst) pend <= 1'b0;
        else if (go) pend <= 1'b1;
        else if (drv_fin) pend <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            blk0_r  <= '0;
            blk1_r  <= '0;
            page_r  <= '0;
            col_r   <= '0;
            nb_r    <= '0;
            cnt     <= '0;
            pass_r  <= 1'b0;
            fault_r <= FLT_NONE;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    blk0_r <= blk_p0;
                    blk1_r <= blk_p1;
                    page_r <= page;
                    col_r  <= col;
                    nb_r   <= nbytes;
                    cnt    <= '0;
                    pass_r <= 1'b0;
                    if (req_ok) begin
                        fault_r <= FLT_NONE;
                        state   <= S_OP0;
                    end else begin
                        fault_r <= FLT_ADDR;
                        state   <= S_FIN;
                    end
                end
                S_OP0: if (drv_fin) state <= S_ADR0;
                S_OP1: if (drv_fin) state <= S_ADR1;
                S_OPD: if (drv_fin) state <= S_WD;
                S_OPP: if (drv_fin) state <= S_WP;
                S_OPS: if (drv_fin) state <= S_RDS;
                S_ADR0, S_ADR1: if (drv_fin) begin
                    if (cnt[2:0] == ADDR_LAST) begin
                        cnt   <= '0;
                        state <= (state == S_ADR0) ? S_DAT0 : S_DAT1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_DAT0, S_DAT1: if (drv_fin) begin
                    if (cnt == nb_r - 1'b1) begin
                        cnt   <= '0;
                        state <= (state == S_DAT0) ? S_OPD : S_OPP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_WD, S_WP: begin
                    if (tmr_ready) begin
                        state <= (state == S_WD) ? S_OP1 : S_OPS;
                    end else if (tmr_expired) begin
                        fault_r <= FLT_TIMEOUT;
                        state   <= S_FIN;
                    end
                end
                S_RDS: if (drv_fin) begin
                    pass_r  <= !stat_fail;
                    fault_r <= stat_fail ? FLT_PROG : FLT_NONE;
                    state   <= S_FIN;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign done        = (state == S_FIN);
    assign pass        = pass_r;
    assign fault       = fault_r;
    assign nand_chip_n = (state == S_IDLE) || (state == S_FIN);

    nmp_cycle_drv #(.T_LO(T_LO), .T_HI(T_HI)) u_drv (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .cyc     (cyc),
        .idle    (drv_idle),
        .fin     (drv_fin),
        .rd_byte (rd_byte),
        .cle     (nand_cmd_latch),
        .ale     (nand_addr_latch),
        .we_n    (nand_wr_n),
        .re_n    (nand_rd_n),
        .io_out  (nand_dq_out),
        .io_oe   (nand_dq_oe),
        .io_in   (nand_dq_in)
    );

    nmp_busy_wait #(.T_WB(T_WB), .TIMEOUT(TIMEOUT)) u_wait (
        .clk     (clk),
        .rst     (rst),
        .en      (tmr_en),
        .rb_n    (nand_ready),
        .ready   (tmr_ready),
        .expired (tmr_expired)
    );

    // R1
    reject_no_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && start && !req_ok) |=> (done && fault == FLT_ADDR && nand_chip_n));

    // R5
    no_strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(nand_wr_n) |-> nand_ready);

    // R7
    pass_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fault == FLT_NONE) |-> pass);

    // R8
    timeout_end_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_expired |=> (done && fault == FLT_TIMEOUT && !pass));

    // R9
    take_then_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (din_valid && din_ready) |=> !nand_wr_n);

    // R11
    strobe_selected_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(nand_wr_n) |-> !nand_chip_n);

endmodule

// File: tb/nand_mp_prog_test.sv
module nand_mp_prog_test;
    localparam int BLK_W = 11, PAGE_W = 6, COL_W = 12, PAGE_BYTES = 2112;
    localparam int T_LO = 2, T_HI = 2, T_WB = 2, TIMEOUT = 300;
    localparam int NB_W = $clog2(PAGE_BYTES + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic              start = 1'b0;
    logic [BLK_W-1:0]  blk_p0 = '0, blk_p1 = '0;
    logic [PAGE_W-1:0] page = '0;
    logic [COL_W-1:0]  col = '0;
    logic [NB_W-1:0]   nbytes = '0;
    logic              din_valid = 1'b0;
    logic [7:0]        din_data = '0;
    logic              din_ready, done, pass;
    logic [1:0]        fault;
    logic              nand_chip_n, nand_cmd_latch, nand_addr_latch, nand_wr_n, nand_rd_n, nand_dq_oe;
    logic [7:0]        nand_dq_out, nand_dq_in;
    logic              nand_ready;

    int checks = 0, errors = 0;
    bit [9:0] log_q[$];
    bit [9:0] exp_q[$];
    bit [7:0] src_q[$];
    int   rb_cnt = 0;
    bit   rb_hold = 0, stuck_mode = 0, gap_mode = 0, ce_seen = 0;
    logic [7:0] stat_val = 8'hE0;
    int   rd_pulses = 0, lo_len = 0, re_len = 0, tick = 0;
    bit   prev_we = 1, prev_re = 1;

    assign nand_ready = !((rb_cnt > 0) || rb_hold);
    assign nand_dq_in = nand_rd_n ? 8'h00 : stat_val;

    nand_mp_prog #(.BLK_W(BLK_W), .PAGE_W(PAGE_W), .COL_W(COL_W), .PAGE_BYTES(PAGE_BYTES),
                   .T_LO(T_LO), .T_HI(T_HI), .T_WB(T_WB), .TIMEOUT(TIMEOUT)) uut (
        .clk(clk), .rst(rst), .start(start), .blk_p0(blk_p0), .blk_p1(blk_p1),
        .page(page), .col(col), .nbytes(nbytes),
        .din_valid(din_valid), .din_data(din_data), .din_ready(din_ready),
        .done(done), .pass(pass), .fault(fault),
        .nand_chip_n(nand_chip_n), .nand_cmd_latch(nand_cmd_latch), .nand_addr_latch(nand_addr_latch),
        .nand_wr_n(nand_wr_n), .nand_rd_n(nand_rd_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_ready(nand_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // flash model and per-clock protocol watch
    always @(negedge clk) begin
        if (!rst) begin
            if (nand_cmd_latch && nand_addr_latch) chk(0, "R4", "both latch lines high", 1, 0);
            if (!nand_chip_n) ce_seen = 1;
            if (!nand_wr_n) begin
                if (nand_chip_n) chk(0, "R11", "strobe with chip deselected", 1, 0);
                if (!nand_ready) chk(0, "R5", "strobe while busy", 0, 1);
                lo_len++;
            end else if (!prev_we) begin
                chk(lo_len == T_LO, "R10", "strobe low width", lo_len, T_LO);
                log_q.push_back({nand_cmd_latch, nand_addr_latch, nand_dq_out});
                if (nand_cmd_latch && nand_dq_out == 8'h11) rb_cnt = 7;
                if (nand_cmd_latch && nand_dq_out == 8'h10) begin
                    if (stuck_mode) rb_hold = 1;
                    else rb_cnt = 25;
                end
                lo_len = 0;
            end
            if (!nand_rd_n) re_len++;
            else if (!prev_re) begin
                chk(re_len == T_LO, "R6", "read strobe low width", re_len, T_LO);
                rd_pulses++;
                re_len = 0;
            end
            if (rb_cnt > 0) rb_cnt--;
        end
        prev_we = nand_wr_n;
        prev_re = nand_rd_n;
    end

    // stream source
    initial begin
        forever begin
            @(negedge clk);
            tick++;
            if (src_q.size() > 0 && !(gap_mode && (tick % 3 != 0))) begin
                din_valid = 1'b1;
                din_data  = src_q[0];
                #1;
                if (din_ready) void'(src_q.pop_front());
            end else begin
                din_valid = 1'b0;
            end
        end
    end

    function automatic bit [7:0] pat(input int i, input int p, input int seed);
        return 8'((i * 7 + p * 101 + seed) & 255);
    endfunction

    task automatic push_addr(input int c, input int r);
        exp_q.push_back({2'b01, 8'(c & 255)});
        exp_q.push_back({2'b01, 8'((c >> 8) & 255)});
        exp_q.push_back({2'b01, 8'(r & 255)});
        exp_q.push_back({2'b01, 8'((r >> 8) & 255)});
        exp_q.push_back({2'b01, 8'((r >> 16) & 255)});
    endtask

    task automatic do_op(input int b0, input int b1, input int pg, input int cl, input int n,
                         input int exp_fault, input bit gaps, input bit stuck, input bit pfail,
                         input int seed, input string req);
        int waited = 0;
        bit seen = 0;
        int f = 0, p = 0, mism = 0, first_bad = -1;
        log_q.delete(); exp_q.delete(); src_q.delete();
        rd_pulses = 0; ce_seen = 0;
        gap_mode = gaps; stuck_mode = stuck;
        stat_val = pfail ? 8'hE1 : 8'hE0;
        if (exp_fault == 1) begin
            src_q.push_back(8'h5A);
        end else begin
            exp_q.push_back({2'b10, 8'h80});
            push_addr(cl, b0 * 64 + pg);
            for (int i = 0; i < n; i++) begin
                exp_q.push_back({2'b00, pat(i, 0, seed)});
                src_q.push_back(pat(i, 0, seed));
            end
            exp_q.push_back({2'b10, 8'h11});
            exp_q.push_back({2'b10, 8'h81});
            push_addr(cl, b1 * 64 + pg);
            for (int i = 0; i < n; i++) begin
                exp_q.push_back({2'b00, pat(i, 1, seed)});
                src_q.push_back(pat(i, 1, seed));
            end
            exp_q.push_back({2'b10, 8'h10});
            if (!stuck) exp_q.push_back({2'b10, 8'h70});
        end
        @(negedge clk);
        blk_p0 = BLK_W'(b0); blk_p1 = BLK_W'(b1); page = PAGE_W'(pg);
        col = COL_W'(cl); nbytes = NB_W'(n);
        start = 1'b1;
        while (!seen && waited < 60000) begin
            @(negedge clk);
            start = 1'b0;
            if (done) begin
                seen = 1; f = int'(fault); p = int'(pass);
            end
            waited++;
        end
        chk(seen, req, "done observed", seen, 1);
        chk(f == exp_fault, req, "fault code", f, exp_fault);
        chk(p == (exp_fault == 0 ? 1 : 0), "R7", "pass flag", p, exp_fault == 0 ? 1 : 0);
        @(negedge clk);
        chk(done == 1'b0, "R11", "done lasts one clock", done, 0);
        chk(nand_chip_n == 1'b1, "R11", "chip deselected when idle", nand_chip_n, 1);
        chk(log_q.size() == exp_q.size(), "R3 R5 R6", "bus cycle count", log_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < log_q.size(); i++)
            if (log_q[i] != exp_q[i]) begin
                mism++;
                if (first_bad < 0) first_bad = i;
            end
        if (mism != 0)
            chk(0, "R3 R4 R5", "bus cycle content at index", log_q[first_bad], exp_q[first_bad]);
        else
            chk(1, "R3 R4 R5", "bus cycle content", 0, 0);
        if (exp_fault == 1) begin
            chk(!ce_seen, "R1", "chip never selected", ce_seen, 0);
            chk(src_q.size() == 1, "R1", "stream byte left untaken", src_q.size(), 1);
            src_q.delete();
        end else begin
            chk(src_q.size() == 0, "R9", "all stream bytes taken", src_q.size(), 0);
        end
        if (exp_fault == 0 || exp_fault == 3)
            chk(rd_pulses == 1, "R6", "status read strobes", rd_pulses, 1);
        if (exp_fault == 2) begin
            chk(rd_pulses == 0, "R8", "no status read after timeout", rd_pulses, 0);
            rb_hold = 0;
        end
        repeat (30) @(negedge clk);
    endtask

    initial begin
        #1_900_000;
        checks++;
        errors++;
        $display("FAIL R11 watchdog expired: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(nand_chip_n == 1'b1, "R11", "reset chip select", nand_chip_n, 1);
        chk(nand_wr_n == 1'b1 && nand_rd_n == 1'b1, "R10", "reset strobes idle", {nand_wr_n, nand_rd_n}, 3);
        chk(done == 1'b0 && din_ready == 1'b0, "R9", "reset done/ready", {done, din_ready}, 0);
        chk(nand_dq_oe == 1'b0, "R4", "reset bus not driven", nand_dq_oe, 0);

        // R3 R4 R5 R6 R7: clean program, plain stream
        do_op(12'h2A4, 12'h2A5, 5, 16, 4, 0, 0, 0, 0, 3, "R3");
        // R7 R9: program failure, stalled stream, last column boundary
        do_op(8, 9, 63, 2111, 1, 3, 1, 0, 1, 40, "R7");
        // R1: plane-0 block odd
        do_op(3, 3, 1, 0, 4, 1, 0, 0, 0, 0, "R1");
        // R1: upper block bits differ
        do_op(4, 7, 1, 0, 4, 1, 0, 0, 0, 0, "R1");
        // R2: zero count and overrun of the page
        do_op(4, 5, 1, 0, 0, 1, 0, 0, 0, 0, "R2");
        do_op(4, 5, 1, 2000, 200, 1, 0, 0, 0, 0, "R2");
        // R8: ready held low after final confirm
        do_op(20, 21, 2, 7, 3, 2, 0, 1, 0, 9, "R8");
        // R2 R9: full page on both planes with gaps after a timeout
        do_op(2046, 2047, 0, 0, PAGE_BYTES, 0, 0, 0, 0, 77, "R2");
        do_op(100, 101, 33, 512, 6, 0, 1, 0, 0, 5, "R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule